// File: doc/BRIEF.md
# Frozen-Snapshot Priority Event Access

The block hands one shared address-event output channel to one of `ROWS*COLS` request lines laid out as a two-dimensional grid. When the channel is idle and any line is raised, the block takes a snapshot of all lines. It then picks a winner in two steps. First it takes the lowest row that has any request, using an OR of each row's lines. Then it takes the lowest column within that row. The winner's row and column go out as an address under a four-phase request/acknowledge handshake. The winning line gets its own acknowledge once the receiver acknowledges. A cell keeps its line raised until it sees its acknowledge.

In buffered mode the snapshot stays frozen for the whole handshake. A request that arrives late, even one of higher priority, waits for the next snapshot. Requests are therefore served in arrival order, and priority settles only the ones that coincide. In unbuffered mode, kept for comparison, arbitration uses the live lines. A lower-numbered request that appears while the channel waits for its acknowledge takes over the grant. The displaced event is discarded and counted. The channel address and request always come from flip-flops.

Top module: `evt_pe_access`

## Requirements
- R1: After reset `ch_req_o`, `ack_o` and `drop_cnt_o` are zero, and `ch_req_o` stays low for as long as no line is raised.
- R2: Input index k belongs to row k/COLS and column k%COLS. `ch_addr_o` carries the row in its upper $clog2(ROWS) bits and the column in its lower $clog2(COLS) bits. A request sampled while idle raises `ch_req_o` on the second rising edge after that sample point, not on the first.
- R3: Of requests present together in one snapshot, the lowest index is granted. The others stay pending and are served in later cycles in ascending index order.
- R4: The row is chosen first as the lowest row with any raised line, then the lowest raised column inside that row.
- R5: On the edge where `ch_ack_i` is sampled high while `ch_req_o` is high, `ch_req_o` falls and the acknowledge bit of the winner rises. That bit stays high while `ch_ack_i` stays high and clears on the edge where `ch_ack_i` is sampled low.
- R6: With `buffered_i` = 1, `ch_addr_o` is constant from the rise of `ch_req_o` to the end of the handshake. A request raised meanwhile, of any priority, is served only in a later cycle, and `drop_cnt_o` does not change.
- R7: With `buffered_i` = 0, a raised line with a lower index than the current grant, seen while the acknowledge is awaited, replaces the grant on the next edge while `ch_req_o` stays high. Each displaced input is acknowledged together with the final winner, and its event is discarded. A later line with a higher index changes nothing.
- R8: `drop_cnt_o` increments by one for each displacement and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| buffered_i | input | 1 | 1 = frozen snapshot, 0 = live arbitration with takeover |
| req_i | input | ROWS*COLS | Request line of each cell |
| ch_req_o | output | 1 | Channel request |
| ch_addr_o | output | $clog2(ROWS)+$clog2(COLS) | Row and column of the granted cell |
| ch_ack_i | input | 1 | Channel acknowledge from the receiver |
| ack_o | output | ROWS*COLS | Per-cell acknowledge |
| drop_cnt_o | output | CNT_W | Saturating count of displaced events |

## Verification
The hardest case to reach is a takeover in unbuffered mode. A lower-index line must rise in the narrow window after `ch_req_o` has gone high and before the receiver acknowledges. To stack several takeovers, the next such line must rise before the grant completes. The bench plays the receiver, so it holds `ch_ack_i` low for as long as it wants. While the channel waits, it raises successively lower-numbered lines at chosen negative edges. It repeats the two-line takeover pattern several hundred times to drive the counter into saturation.

// File: rtl/evt_pe_pkg.sv
package evt_pe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_WAIT = 2'd2,
    ST_REL  = 2'd3
  } evt_state_e;
endpackage

// File: rtl/evt_pe_prio_enc.sv
module evt_pe_prio_enc #(
  parameter int unsigned W  = 4,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |vec_i;
endmodule

// File: rtl/evt_pe_grid_enc.sv
module evt_pe_grid_enc #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  localparam int unsigned N     = ROWS * COLS,
  localparam int unsigned RW    = $clog2(ROWS),
  localparam int unsigned CW    = $clog2(COLS),
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [RW-1:0]    row_o,
  output logic [CW-1:0]    col_o,
  output logic [IDX_W-1:0] flat_o
);
  logic [ROWS-1:0] row_any;
  logic [COLS-1:0] col_vec;
  logic            row_valid;
  logic            col_valid;

  for (genvar r = 0; r < ROWS; r++) begin : g_row_or
    assign row_any[r] = |req_i[r*COLS +: COLS];
  end

  evt_pe_prio_enc #(.W(ROWS)) u_row_enc (
    .vec_i  (row_any),
    .valid_o(row_valid),
    .idx_o  (row_o)
  );

  always_comb begin
    col_vec = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_o == RW'(r)) col_vec = req_i[r*COLS +: COLS];
    end
  end

  evt_pe_prio_enc #(.W(COLS)) u_col_enc (
    .vec_i  (col_vec),
    .valid_o(col_valid),
    .idx_o  (col_o)
  );

  assign valid_o = row_valid & col_valid;
  assign flat_o  = IDX_W'(row_o) * IDX_W'(COLS) + IDX_W'(col_o);
endmodule

// File: rtl/evt_pe_sat_cnt.sv
module evt_pe_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (inc_i && (~cnt_o != '0)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/evt_pe_access.sv
module evt_pe_access
  import evt_pe_pkg::*;
#(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  buffered_i,
  input  logic [ROWS*COLS-1:0]                  req_i,
  output logic                                  ch_req_o,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  ch_addr_o,
  input  logic                                  ch_ack_i,
  output logic [ROWS*COLS-1:0]                  ack_o,
  output logic [CNT_W-1:0]                      drop_cnt_o
);
  localparam int unsigned N     = ROWS * COLS;
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned CW    = $clog2(COLS);
  localparam int unsigned IDX_W = $clog2(N);

  evt_state_e       state_q;
  logic [N-1:0]     snap_q;
  logic [N-1:0]     arb_src;
  logic [N-1:0]     lost_q;
  logic [N-1:0]     ack_q;
  logic [N-1:0]     win_mask;
  logic [RW-1:0]    win_row_q;
  logic [CW-1:0]    win_col_q;
  logic [IDX_W-1:0] win_flat_q;
  logic             ch_req_q;
  logic             enc_valid;
  logic [RW-1:0]    enc_row;
  logic [CW-1:0]    enc_col;
  logic [IDX_W-1:0] enc_flat;
  logic             takeover;

  // buffered: frozen snapshot; unbuffered: live lines
  assign arb_src = buffered_i ? snap_q : req_i;

  evt_pe_grid_enc #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .req_i  (arb_src),
    .valid_o(enc_valid),
    .row_o  (enc_row),
    .col_o  (enc_col),
    .flat_o (enc_flat)
  );

  always_comb begin
    win_mask = '0;
    win_mask[win_flat_q] = 1'b1;
  end

  assign takeover = (state_q == ST_WAIT) && !ch_ack_i && !buffered_i &&
                    enc_valid && (enc_flat < win_flat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      snap_q     <= '0;
      lost_q     <= '0;
      ack_q      <= '0;
      win_row_q  <= '0;
      win_col_q  <= '0;
      win_flat_q <= '0;
      ch_req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (|req_i) begin
            snap_q  <= req_i;
            state_q <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (enc_valid) begin
            win_row_q  <= enc_row;
            win_col_q  <= enc_col;
            win_flat_q <= enc_flat;
            ch_req_q   <= 1'b1;
            state_q    <= ST_WAIT;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (ch_ack_i) begin
            ack_q    <= win_mask | lost_q;
            ch_req_q <= 1'b0;
            state_q  <= ST_REL;
          end else if (takeover) begin
            lost_q     <= lost_q | win_mask;
            win_row_q  <= enc_row;
            win_col_q  <= enc_col;
            win_flat_q <= enc_flat;
          end
        end
        ST_REL: begin
          if (!ch_ack_i) begin
            ack_q   <= '0;
            lost_q  <= '0;
            snap_q  <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  evt_pe_sat_cnt #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (takeover),
    .cnt_o (drop_cnt_o)
  );

  assign ch_req_o  = ch_req_q;
  assign ch_addr_o = {win_row_q, win_col_q};
  assign ack_o     = ack_q;
endmodule

// File: rtl/evt_pe_access_chk.sv
module evt_pe_access_chk #(
  parameter int unsigned N      = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              buffered_i,
  input logic              ch_req_o,
  input logic [ADDR_W-1:0] ch_addr_o,
  input logic              ch_ack_i,
  input logic [N-1:0]      ack_o,
  input logic [CNT_W-1:0]  drop_cnt_o
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o && !ch_ack_i) |=> ch_req_o);

  p_ack_after_chack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|ack_o) |-> $past(ch_ack_i));

  p_ack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ack_o) && !ch_ack_i) |=> !(|ack_o));

  p_req_ack_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch_req_o && (|ack_o)));

  p_addr_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o && buffered_i) |=> ($stable(ch_addr_o) || !buffered_i));

  p_drop_unbuf_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> !$past(buffered_i));

  p_drop_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));
endmodule

bind evt_pe_access evt_pe_access_chk #(
  .N     (ROWS * COLS),
  .ADDR_W($clog2(ROWS) + $clog2(COLS)),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .buffered_i(buffered_i),
  .ch_req_o  (ch_req_o),
  .ch_addr_o (ch_addr_o),
  .ch_ack_i  (ch_ack_i),
  .ack_o     (ack_o),
  .drop_cnt_o(drop_cnt_o)
);

// File: tb/evt_pe_access_tb.sv
`timescale 1ns/1ps
module evt_pe_access_tb;
  localparam int unsigned ROWS  = 4;
  localparam int unsigned COLS  = 4;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned N     = ROWS * COLS;
  localparam int unsigned AW    = $clog2(ROWS) + $clog2(COLS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             buffered = 1'b1;
  logic [N-1:0]     req = '0;
  logic             ch_req;
  logic [AW-1:0]    ch_addr;
  logic             ch_ack = 1'b0;
  logic [N-1:0]     ack;
  logic [CNT_W-1:0] drop_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  evt_pe_access #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .buffered_i(buffered),
    .req_i     (req),
    .ch_req_o  (ch_req),
    .ch_addr_o (ch_addr),
    .ch_ack_i  (ch_ack),
    .ack_o     (ack),
    .drop_cnt_o(drop_cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] bit_of(input int k);
    logic [N-1:0] m = '0;
    m[k] = 1'b1;
    return m;
  endfunction

  task automatic wait_req(input string tag);
    int n = 0;
    while (ch_req !== 1'b1 && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " ch_req rises"}, 32'(ch_req), 32'd1);
  endtask

  // receiver side of one handshake; cells drop lines they see acknowledged
  task automatic serve(input string tag, input int exp_idx, input logic [N-1:0] exp_mask);
    wait_req(tag);
    chk({tag, " addr"}, 32'(ch_addr), 32'(exp_idx));
    ch_ack = 1'b1;
    @(negedge clk);
    chk({tag, " ack mask (R5)"}, 32'(ack), 32'(exp_mask));
    chk({tag, " ch_req low (R5)"}, 32'(ch_req), 32'd0);
    req    = req & ~ack;
    ch_ack = 1'b0;
    @(negedge clk);
    chk({tag, " ack cleared (R5)"}, 32'(ack), 32'd0);
  endtask

  task automatic t_reset_idle();
    chk("R1 ch_req at reset", 32'(ch_req), 32'd0);
    chk("R1 ack at reset", 32'(ack), 32'd0);
    chk("R1 drop at reset", 32'(drop_cnt), 32'd0);
    repeat (10) @(negedge clk);
    chk("R1 idle no request", 32'(ch_req), 32'd0);
  endtask

  task automatic t_single_timing();
    req = bit_of(6);
    @(negedge clk);
    chk("R2 not after first edge", 32'(ch_req), 32'd0);
    @(negedge clk);
    chk("R2 after second edge", 32'(ch_req), 32'd1);
    chk("R2 row1 col2 addr", 32'(ch_addr), 32'h6);
    serve("R2 single", 6, bit_of(6));
  endtask

  task automatic t_coincident();
    req = bit_of(9) | bit_of(3) | bit_of(14);
    serve("R3 first", 3, bit_of(3));
    serve("R3 second", 9, bit_of(9));
    serve("R3 third", 14, bit_of(14));
  endtask

  task automatic t_rows();
    req = bit_of(12) | bit_of(8) | bit_of(7);
    serve("R4 row1 col3", 7, bit_of(7));
    serve("R4 row2 col0", 8, bit_of(8));
    serve("R4 row3 col0", 12, bit_of(12));
  endtask

  task automatic t_buffered_freeze();
    logic [CNT_W-1:0] c0 = drop_cnt;
    req = bit_of(10);
    wait_req("R6 freeze");
    req[2] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 addr frozen", 32'(ch_addr), 32'd10);
    end
    serve("R6 old served", 10, bit_of(10));
    serve("R6 late served next", 2, bit_of(2));
    chk("R6 drop unchanged", 32'(drop_cnt), 32'(c0));
  endtask

  task automatic t_ack_hold();
    req = bit_of(5);
    wait_req("R5 hold");
    ch_ack = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 ack held", 32'(ack), 32'(bit_of(5)));
    end
    req    = '0;
    ch_ack = 1'b0;
    @(negedge clk);
    chk("R5 ack released", 32'(ack), 32'd0);
  endtask

  task automatic t_takeover();
    buffered = 1'b0;
    req = bit_of(11);
    wait_req("R7 takeover");
    req[4] = 1'b1;
    @(negedge clk);
    chk("R7 addr replaced", 32'(ch_addr), 32'd4);
    chk("R7 ch_req held", 32'(ch_req), 32'd1);
    chk("R8 count one", 32'(drop_cnt), 32'd1);
    serve("R7 winner and lost", 4, bit_of(4) | bit_of(11));
  endtask

  task automatic t_double_takeover();
    req = bit_of(12);
    wait_req("R7 double");
    req[8] = 1'b1;
    @(negedge clk);
    req[1] = 1'b1;
    @(negedge clk);
    chk("R7 double addr", 32'(ch_addr), 32'd1);
    chk("R8 count three", 32'(drop_cnt), 32'd3);
    serve("R7 double acks", 1, bit_of(1) | bit_of(8) | bit_of(12));
  endtask

  task automatic t_lower_arrival();
    req = bit_of(3);
    wait_req("R7 no takeover");
    req[9] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 higher index ignored", 32'(ch_addr), 32'd3);
    chk("R8 count still three", 32'(drop_cnt), 32'd3);
    serve("R7 keep", 3, bit_of(3));
    serve("R7 then later", 9, bit_of(9));
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 260; i++) begin
      req = bit_of(15);
      wait_req("R8 sat");
      req[0] = 1'b1;
      @(negedge clk);
      serve("R8 sat cycle", 0, bit_of(0) | bit_of(15));
    end
    chk("R8 saturated", 32'(drop_cnt), 32'd255);
    buffered = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_single_timing();
    t_coincident();
    t_rows();
    t_buffered_freeze();
    t_ack_hold();
    t_takeover();
    t_double_takeover();
    t_lower_arrival();
    t_saturate();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule